// File: doc/BRIEF.md
# ModR/M and SIB effective-address decoder

This block sits behind the prefix and opcode stages of an instruction decoder. It takes the operand-addressing bytes of one instruction, one byte per cycle over a valid/ready handshake, starting with the ModR/M byte. From the mode and R/M fields it works out whether a scale-index-base byte follows and how many displacement bytes follow (none, one, two or four). It collects those bytes and then reports the decoded operand.

The report appears in a one-cycle `done` pulse. It carries the reg/opcode field, whether the operand is a register or a memory reference, the register number for register forms, the effective address and the number of bytes consumed. The effective address is formed from a snapshot of the eight general registers that the surrounding pipeline presents on `regs_flat`; the snapshot must be valid during the `done` cycle. A mode input selects 32-bit or 16-bit addressing. It is sampled together with the ModR/M byte and holds for the rest of that instruction.

Top module: `modrm_addr_decoder`

## Requirements
- R1: `byte_ready` is high in every cycle except the `done` cycle, and a byte is consumed only in a cycle where `byte_valid` and `byte_ready` are both high. Idle cycles between bytes are allowed.
- R2: `done` is high for exactly one cycle, in the cycle after the last byte of an instruction is accepted. `byte_count` then equals the number of bytes accepted for that instruction, which is 1 to 6.
- R3: `reg_field` reports ModR/M bits 5:3. Mod (bits 7:6) equal to 3 is a register operand: `is_reg`=1, `rm_reg` = R/M (bits 2:0), `eff_addr`=0 and `byte_count`=1.
- R4: In 32-bit mode with R/M not 4, the address is the register selected by R/M plus the displacement. Registers are numbered 0..7 in the order accumulator, counter, data, base, stack pointer, frame pointer, source, destination. Mod 0 has no displacement. Mod 1 has one byte, sign-extended. Mod 2 has four bytes, little-endian.
- R5: In 32-bit mode with R/M=4 and mod not 3, a SIB byte follows, with scale in bits 7:6, index in bits 5:3 and base in bits 2:0. The address is base + (index << scale) + displacement, using the same mod rules as R4.
- R6: A SIB index of 4 contributes no index term, whatever the scale.
- R7: A SIB base of 5 with mod 0 replaces the base register with a 4-byte displacement, so the instruction is 6 bytes long.
- R8: In 32-bit mode, mod 0 with R/M=5 is a bare 4-byte displacement with no register term, and the instruction is 5 bytes long.
- R9: In 16-bit mode, R/M 0..7 selects BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP and BX. These are the low halves of registers 3, 6, 7 and 5. Mod 1 adds a sign-extended byte and mod 2 adds a 2-byte little-endian displacement.
- R10: In 16-bit mode, mod 0 with R/M=6 is a bare 2-byte displacement. Every 16-bit sum wraps modulo 2^16, and `eff_addr[31:16]` is 0.
- R11: The addressing mode is taken from `addr16` in the cycle the ModR/M byte is accepted (1 = 16-bit). Later changes of `addr16` do not affect that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr16 | input | 1 | 1 selects 16-bit addressing, sampled with the ModR/M byte |
| byte_valid | input | 1 | Instruction byte on `byte_data` is valid |
| byte_data | input | 8 | Instruction byte |
| byte_ready | output | 1 | Block can accept a byte this cycle |
| regs_flat | input | 256 | Register snapshot, register i in bits 32*i+31:32*i |
| done | output | 1 | One-cycle pulse with the decoded operand |
| reg_field | output | 3 | ModR/M reg/opcode field |
| is_reg | output | 1 | Operand is a register |
| rm_reg | output | 3 | Register number of a register operand |
| eff_addr | output | 32 | Effective address of a memory operand |
| byte_count | output | 3 | Bytes consumed for this instruction |

## Verification
The bench sweeps every mod and R/M value in both modes, and every SIB byte under each memory mod, with fresh register values and displacements on each pass.

The escape encodings are the sharp corners. A decoder that treats SIB base 5 or ModR/M R/M 5 under mod 0 as a register would add a stray register and stop a byte early. One that honours index 4 would add a scaled stack pointer. A 16-bit decoder that reads R/M 6 with mod 0 as BP would read the wrong number of bytes. Zero-extending a negative 8-bit displacement, or carrying past bit 15, shows up as a wrong address.

Stalls between bytes, a byte offered during the `done` cycle, and a mode flip in the middle of an instruction check that bytes are neither lost nor doubled and that the mode is latched.

// File: rtl/modrm_addr_decoder.sv
module modrm_addr_decoder #(
  parameter int RW   = 32,
  parameter int NREG = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               addr16,
  input  logic               byte_valid,
  input  logic [7:0]         byte_data,
  output logic               byte_ready,
  input  logic [NREG*RW-1:0] regs_flat,
  output logic               done,
  output logic [2:0]         reg_field,
  output logic               is_reg,
  output logic [2:0]         rm_reg,
  output logic [RW-1:0]      eff_addr,
  output logic [2:0]         byte_count
);

  typedef enum logic [1:0] {ST_MODRM, ST_SIB, ST_DISP, ST_DONE} st_t;

  st_t        st;
  logic       a16_q, has_sib_q;
  logic [7:0] modrm_q, sib_q;
  logic [RW-1:0] disp_q;
  logic [2:0] disp_len_q, disp_left_q, cnt_q;
  logic [1:0] disp_pos_q;

  logic       accept;
  logic [1:0] in_mod;
  logic [2:0] in_rm;
  logic [2:0] len_modrm, len_sib;

  assign byte_ready = (st != ST_DONE);
  assign accept     = byte_valid & byte_ready;
  assign in_mod     = byte_data[7:6];
  assign in_rm      = byte_data[2:0];

  always_comb begin
    len_modrm = 3'd0;
    if (in_mod == 2'd1)      len_modrm = 3'd1;
    else if (in_mod == 2'd2) len_modrm = addr16 ? 3'd2 : 3'd4;
    else if (in_mod == 2'd0) begin
      if (addr16 && in_rm == 3'd6)       len_modrm = 3'd2;
      else if (!addr16 && in_rm == 3'd5) len_modrm = 3'd4;
    end
  end

  always_comb begin
    len_sib = 3'd0;
    if (modrm_q[7:6] == 2'd1)      len_sib = 3'd1;
    else if (modrm_q[7:6] == 2'd2) len_sib = 3'd4;
    else if (in_rm == 3'd5)        len_sib = 3'd4;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_MODRM;
      a16_q       <= 1'b0;
      has_sib_q   <= 1'b0;
      modrm_q     <= '0;
      sib_q       <= '0;
      disp_q      <= '0;
      disp_len_q  <= '0;
      disp_left_q <= '0;
      disp_pos_q  <= '0;
      cnt_q       <= '0;
    end else begin
      case (st)
        ST_MODRM: if (accept) begin
          modrm_q    <= byte_data;
          a16_q      <= addr16;
          has_sib_q  <= 1'b0;
          sib_q      <= '0;
          disp_q     <= '0;
          disp_pos_q <= '0;
          cnt_q      <= 3'd1;
          if (in_mod != 2'd3 && !addr16 && in_rm == 3'd4) begin
            disp_len_q <= 3'd0;
            st         <= ST_SIB;
          end else begin
            disp_len_q  <= (in_mod == 2'd3) ? 3'd0 : len_modrm;
            disp_left_q <= len_modrm;
            st          <= (in_mod == 2'd3 || len_modrm == 3'd0) ? ST_DONE : ST_DISP;
          end
        end
        ST_SIB: if (accept) begin
          sib_q       <= byte_data;
          has_sib_q   <= 1'b1;
          cnt_q       <= cnt_q + 3'd1;
          disp_len_q  <= len_sib;
          disp_left_q <= len_sib;
          st          <= (len_sib == 3'd0) ? ST_DONE : ST_DISP;
        end
        ST_DISP: if (accept) begin
          disp_q[8*disp_pos_q +: 8] <= byte_data;
          disp_pos_q  <= disp_pos_q + 2'd1;
          disp_left_q <= disp_left_q - 3'd1;
          cnt_q       <= cnt_q + 3'd1;
          if (disp_left_q == 3'd1) st <= ST_DONE;
        end
        default: st <= ST_MODRM;
      endcase
    end
  end

  function automatic logic [RW-1:0] rd(input logic [2:0] idx);
    return regs_flat[RW*idx +: RW];
  endfunction

  logic [1:0]    mod_q;
  logic [2:0]    rm_q, base_sel;
  logic          base_en, idx_en;
  logic [RW-1:0] disp_ext, ea32, base_val, idx_val;
  logic [15:0]   b16, i16, ea16;

  assign mod_q = modrm_q[7:6];
  assign rm_q  = modrm_q[2:0];

  always_comb begin
    case (disp_len_q)
      3'd1:    disp_ext = {{(RW-8){disp_q[7]}}, disp_q[7:0]};
      3'd2:    disp_ext = {{(RW-16){1'b0}}, disp_q[15:0]};
      3'd4:    disp_ext = disp_q;
      default: disp_ext = '0;
    endcase
  end

  assign base_sel = has_sib_q ? sib_q[2:0] : rm_q;
  assign base_en  = !(base_sel == 3'd5 && mod_q == 2'd0);
  assign idx_en   = has_sib_q && sib_q[5:3] != 3'd4;
  assign base_val = base_en ? rd(base_sel) : '0;
  assign idx_val  = idx_en ? (rd(sib_q[5:3]) << sib_q[7:6]) : '0;
  assign ea32     = base_val + idx_val + disp_ext;

  always_comb begin
    b16 = '0;
    i16 = '0;
    case (rm_q)
      3'd0: begin b16 = rd(3'd3)[15:0]; i16 = rd(3'd6)[15:0]; end
      3'd1: begin b16 = rd(3'd3)[15:0]; i16 = rd(3'd7)[15:0]; end
      3'd2: begin b16 = rd(3'd5)[15:0]; i16 = rd(3'd6)[15:0]; end
      3'd3: begin b16 = rd(3'd5)[15:0]; i16 = rd(3'd7)[15:0]; end
      3'd4: b16 = rd(3'd6)[15:0];
      3'd5: b16 = rd(3'd7)[15:0];
      3'd6: if (mod_q != 2'd0) b16 = rd(3'd5)[15:0];
      default: b16 = rd(3'd3)[15:0];
    endcase
  end

  assign ea16 = b16 + i16 + disp_ext[15:0];

  assign done       = (st == ST_DONE);
  assign reg_field  = modrm_q[5:3];
  assign is_reg     = (mod_q == 2'd3);
  assign rm_reg     = rm_q;
  assign byte_count = cnt_q;
  assign eff_addr   = is_reg ? '0 : (a16_q ? {{(RW-16){1'b0}}, ea16} : ea32);

endmodule

// File: rtl/modrm_addr_decoder_chk.sv
module modrm_addr_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        addr16,
  input logic        byte_valid,
  input logic        byte_ready,
  input logic        done,
  input logic        is_reg,
  input logic [2:0]  byte_count,
  input logic [31:0] eff_addr
);

  logic [2:0] acc_cnt;
  logic       mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_cnt <= '0;
      mode_q  <= 1'b0;
    end else begin
      if (done) acc_cnt <= '0;
      else if (byte_valid && byte_ready) acc_cnt <= acc_cnt + 3'd1;
      if (byte_valid && byte_ready && acc_cnt == 3'd0) mode_q <= addr16;
    end
  end

  AST_READY_LOW_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !byte_ready); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R2
  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(byte_valid && byte_ready)); // R2
  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n) done |-> (byte_count == acc_cnt && byte_count != 3'd0 && byte_count <= 3'd6)); // R2
  AST_REG_FORM_SHORT: assert property (@(posedge clk) disable iff (!rst_n) (done && is_reg) |-> (byte_count == 3'd1 && eff_addr == 32'd0)); // R3
  AST_MODE16_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n) (done && mode_q) |-> (eff_addr[31:16] == 16'd0 && byte_count <= 3'd3)); // R10

endmodule

bind modrm_addr_decoder modrm_addr_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr16(addr16), .byte_valid(byte_valid),
  .byte_ready(byte_ready), .done(done), .is_reg(is_reg),
  .byte_count(byte_count), .eff_addr(eff_addr)
);

// File: tb/tb_modrm_addr_decoder.sv
module tb_modrm_addr_decoder;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         addr16 = 1'b0;
  logic         byte_valid = 1'b0;
  logic [7:0]   byte_data = '0;
  logic         byte_ready;
  logic [255:0] regs_flat;
  logic         done;
  logic [2:0]   reg_field;
  logic         is_reg;
  logic [2:0]   rm_reg;
  logic [31:0]  eff_addr;
  logic [2:0]   byte_count;

  logic [31:0] r [8];
  logic [7:0]  bq [6];
  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  always_comb for (int i = 0; i < 8; i++) regs_flat[32*i +: 32] = r[i];

  always #(CLK_PERIOD/2) clk = ~clk;

  modrm_addr_decoder dut (
    .clk(clk), .rst_n(rst_n), .addr16(addr16), .byte_valid(byte_valid),
    .byte_data(byte_data), .byte_ready(byte_ready), .regs_flat(regs_flat),
    .done(done), .reg_field(reg_field), .is_reg(is_reg), .rm_reg(rm_reg),
    .eff_addr(eff_addr), .byte_count(byte_count)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      nfail++;
      $display("FAIL watchdog: actual=%0d cycles expected<=200000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int dlen(bit a16, logic [7:0] m, logic [7:0] s);
    if (m[7:6] == 2'd3) return 0;
    if (m[7:6] == 2'd1) return 1;
    if (m[7:6] == 2'd2) return a16 ? 2 : 4;
    if (a16) return (m[2:0] == 3'd6) ? 2 : 0;
    if (m[2:0] == 3'd5) return 4;
    if (m[2:0] == 3'd4 && s[2:0] == 3'd5) return 4;
    return 0;
  endfunction

  function automatic logic [31:0] exp_ea(bit a16, logic [7:0] m, logic [7:0] s, logic [31:0] d);
    logic [31:0] dx, base, idx;
    logic [15:0] h;
    int md = m[7:6];
    int rm = m[2:0];
    if (md == 3) return 32'd0;
    if (a16) begin
      logic [15:0] bx = r[3][15:0], bp = r[5][15:0], si = r[6][15:0], di = r[7][15:0];
      logic [15:0] dd = (md == 1) ? {{8{d[7]}}, d[7:0]} : ((md == 2 || rm == 6) ? d[15:0] : 16'd0);
      case (rm)
        0: h = bx + si;
        1: h = bx + di;
        2: h = bp + si;
        3: h = bp + di;
        4: h = si;
        5: h = di;
        6: h = (md == 0) ? 16'd0 : bp;
        default: h = bx;
      endcase
      h = h + dd;
      return {16'd0, h};
    end
    dx = (md == 1) ? {{24{d[7]}}, d[7:0]} : ((dlen(0, m, s) == 4) ? d : 32'd0);
    idx = 32'd0;
    if (rm == 4) begin
      base = (md == 0 && s[2:0] == 3'd5) ? 32'd0 : r[s[2:0]];
      if (s[5:3] != 3'd4) idx = r[s[5:3]] << s[7:6];
    end else begin
      base = (md == 0 && rm == 5) ? 32'd0 : r[rm];
    end
    return base + idx + dx;
  endfunction

  task automatic send(input int n, input bit gaps);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (gaps) begin
        byte_valid = 1'b0;
        @(negedge clk);
      end
      byte_valid = 1'b1;
      byte_data  = bq[k];
      while (!byte_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic run_one(bit a16, logic [7:0] m, logic [7:0] s, bit gaps, string tag);
    logic [31:0] d = $urandom;
    bit has_s = !a16 && m[7:6] != 2'd3 && m[2:0] == 3'd4;
    int len = dlen(a16, m, s);
    int n = 0;
    int cnt;
    bq[n++] = m;
    if (has_s) bq[n++] = s;
    for (int k = 0; k < len; k++) bq[n++] = d[8*k +: 8];
    cnt = n;
    addr16 = a16;
    send(n, gaps);
    chk(done === 1'b1, "R2 done", {31'd0, done}, 32'd1);
    chk(byte_count == 3'(cnt), "R2 count", {29'd0, byte_count}, cnt);
    chk(reg_field == m[5:3], "R3 reg_field", {29'd0, reg_field}, {29'd0, m[5:3]});
    chk(is_reg == (m[7:6] == 2'd3), "R3 is_reg", {31'd0, is_reg}, {31'd0, m[7:6] == 2'd3});
    if (m[7:6] == 2'd3) chk(rm_reg == m[2:0], "R3 rm_reg", {29'd0, rm_reg}, {29'd0, m[2:0]});
    chk(eff_addr == exp_ea(a16, m, s, d), tag, eff_addr, exp_ea(a16, m, s, d));
    @(negedge clk);
    chk(done === 1'b0, "R2 pulse", {31'd0, done}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) r[i] = $urandom;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done === 1'b0, "R2 reset done", {31'd0, done}, 32'd0);
    chk(byte_ready === 1'b1, "R1 reset ready", {31'd0, byte_ready}, 32'd1);

    for (int rep = 0; rep < 3; rep++) begin
      for (int i = 0; i < 8; i++) r[i] = $urandom;
      for (int a = 0; a < 2; a++)
        for (int md = 0; md < 4; md++)
          for (int rm = 0; rm < 8; rm++) begin
            logic [7:0] m = {md[1:0], 3'(rm + rep), rm[2:0]};
            string tag;
            if (md == 3) tag = "R3 eff_addr";
            else if (a == 1) tag = (md == 0 && rm == 6) ? "R10 eff_addr" : "R9 eff_addr";
            else if (rm == 5 && md == 0) tag = "R8 eff_addr";
            else tag = "R4 eff_addr";
            if (a == 0 && md != 3 && rm == 4) begin
              for (int s = 0; s < 256; s++) begin
                logic [7:0] sb = s[7:0];
                if (sb[2:0] == 3'd5 && md == 0) tag = "R7 eff_addr";
                else if (sb[5:3] == 3'd4) tag = "R6 eff_addr";
                else tag = "R5 eff_addr";
                run_one(1'b0, m, sb, (s % 17) == 0, tag);
              end
            end else begin
              run_one(a[0], m, 8'h00, rm == 2, tag);
            end
          end
    end

    // R1: byte offered during the done cycle must wait
    bq[0] = 8'hC8;
    addr16 = 1'b0;
    send(1, 1'b0);
    byte_valid = 1'b1;
    byte_data  = 8'hC1;
    chk(byte_ready === 1'b0, "R1 ready low in done", {31'd0, byte_ready}, 32'd0);
    @(negedge clk);
    chk(byte_ready === 1'b1 && done === 1'b0, "R1 ready back", {30'd0, byte_ready, done}, 32'd2);
    @(posedge clk);
    @(negedge clk);
    byte_valid = 1'b0;
    chk(done === 1'b1 && byte_count == 3'd1 && rm_reg == 3'd1, "R1 held byte decoded",
        {28'd0, done, byte_count}, 32'h9);

    // R11: mode flips after ModR/M accepted
    r[3] = 32'hAAAA_FFF0;
    r[6] = 32'h5555_0020;
    @(negedge clk);
    addr16 = 1'b1;
    byte_valid = 1'b1;
    byte_data = 8'h80;
    @(posedge clk);
    @(negedge clk);
    addr16 = 1'b0;
    byte_data = 8'h34;
    @(posedge clk);
    @(negedge clk);
    byte_valid = 1'b0;
    @(negedge clk);
    byte_valid = 1'b1;
    byte_data = 8'h12;
    @(posedge clk);
    @(negedge clk);
    byte_valid = 1'b0;
    chk(done === 1'b1 && byte_count == 3'd3, "R11 count", {29'd0, byte_count}, 32'd3);
    chk(eff_addr == 32'h0000_1244, "R11 eff_addr", eff_addr, 32'h0000_1244);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule